// File: doc/BRIEF.md
# In-Group Store-to-Load Overlap Detector

This block sits beside an instruction dispatch-group builder. It remembers every store accepted into the current group and warns when a load that arrives later in the same group might read bytes that one of those stores writes. The block never computes a real address. Each memory operation gives two symbolic address operands. Each operand is either a constant offset or a register tag, marked by an is-constant bit. The operation also gives an access size code. The comparison is made on these symbols alone.

A load conflicts with a recorded store in three cases. The first is when both operands match in the same order. The second is when they match in swapped order. The third is when the second operands match, both first operands are constants, and the two byte ranges `[offset, offset+size)` intersect. The `hazard` output is combinational and applies to the operation on the ports in the current cycle. The dispatcher pulses `grp_end` when it closes a group. This empties the table. The table is controlled by a small state machine with three states. TBL_EMPTY means no entry is held. TBL_FILLING means some entries are held. TBL_FULL means all entries are used. Its transitions are: EMPTY→FILLING on the first accepted store. FILLING→FILLING on further stores while space remains. FILLING→FULL when the last free entry is written. FULL→FULL while stores are refused. Any state moves to EMPTY on `grp_end` with no store. Any state moves to FILLING on `grp_end` together with a store.

Top module: `stld_overlap_det`

## Requirements
- R1: When `op_valid` and `op_store` are high and the table is not full, the operation's two operands and its size are written into the next free entry at the clock edge, and the entry count rises by one.
- R2: `op_size` encodes the access width as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes and 4=16 bytes. Codes 5 to 7 behave as 16 bytes.
- R3: A load hits an entry when its (first, second) operands equal the entry's (first, second) operands, or equal them swapped. Equality includes the is-constant bit.
- R4: When the second operands are equal and both first operands are constants, the first values are compared as signed offsets. If the store offset is below the load offset, a hit occurs when store offset + store size > load offset. Otherwise, a hit occurs when load offset + load size > store offset.
- R5: `hazard` can be high only when `op_valid` and `op_load` are high and the table holds at least one entry. Invalid operations and stores never raise it.
- R6: `grp_end` empties the table from the next cycle. In the cycle where `grp_end` is high, `hazard` still reflects the entries recorded before it.
- R7: A store presented together with `grp_end` becomes the only entry of the new group.
- R8: The table holds DEPTH entries (default 5). A store offered when the table is full is not recorded.
- R9: Reset (`rst_n` low) empties the table.
- R10: `hazard` is the OR over all recorded entries. A hit on any single entry, including one that is not the most recent, raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_end | input | 1 | Close current group and clear the table |
| op_valid | input | 1 | An operation is presented this cycle |
| op_load | input | 1 | Presented operation is a load |
| op_store | input | 1 | Presented operation is a store |
| opa_const | input | 1 | First operand is a constant offset |
| opa_val | input | OPND_W | First operand: signed offset or register tag |
| opb_const | input | 1 | Second operand is a constant offset |
| opb_val | input | OPND_W | Second operand: signed offset or register tag |
| op_size | input | 3 | Access size code (see R2) |
| hazard | output | 1 | Presented load may overlap a recorded store |

## Verification
A corrupted entry or a stale valid bit shows up at `hazard` the first time a load is presented whose operands fall on the corrupted field. It does not show up any earlier, so the vector table places probing loads immediately after each store. An entry count that is wrong shows up one group later. A store that is lost makes a load that should hit come back clean. A failed clear makes a load that should be clean come back as a hit in the cycle right after `grp_end`. The boundary vectors sit exactly at range ends that touch but do not overlap. This exposes any off-by-one in the offset sums or the signed compare in the same cycle the load is presented.

// File: rtl/stld_pkg.sv
package stld_pkg;

    localparam int SZ_CODE_W  = 3;
    localparam int SZ_BYTES_W = 5;

    typedef enum logic [1:0] {
        TBL_EMPTY   = 2'd0,
        TBL_FILLING = 2'd1,
        TBL_FULL    = 2'd2
    } tbl_state_e;

    // Access size code to byte count; reserved codes act as the widest access.
    function automatic logic [SZ_BYTES_W-1:0] size_to_bytes(input logic [SZ_CODE_W-1:0] code);
        logic [SZ_BYTES_W-1:0] b;
        case (code)
            3'd0:    b = 5'd1;
            3'd1:    b = 5'd2;
            3'd2:    b = 5'd4;
            3'd3:    b = 5'd8;
            default: b = 5'd16;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/stld_entry_cmp.sv
module stld_entry_cmp #(
    parameter int OPND_W = 12
) (
    input  logic                               ent_vld,
    input  logic                               s_a_c,
    input  logic [OPND_W-1:0]                  s_a_v,
    input  logic                               s_b_c,
    input  logic [OPND_W-1:0]                  s_b_v,
    input  logic [stld_pkg::SZ_BYTES_W-1:0]    s_bytes,
    input  logic                               l_a_c,
    input  logic [OPND_W-1:0]                  l_a_v,
    input  logic                               l_b_c,
    input  logic [OPND_W-1:0]                  l_b_v,
    input  logic [stld_pkg::SZ_BYTES_W-1:0]    l_bytes,
    output logic                               hit
);
    localparam int SUM_W = OPND_W + 1;
    localparam int PAD_W = SUM_W - stld_pkg::SZ_BYTES_W;

    logic same_order, swapped, base_eq, both_const, ranges_meet;
    logic signed [SUM_W-1:0] s_off, l_off, s_end, l_end;

    always_comb begin
        same_order = (s_a_c == l_a_c) && (s_a_v == l_a_v) &&
                     (s_b_c == l_b_c) && (s_b_v == l_b_v);
        swapped    = (s_a_c == l_b_c) && (s_a_v == l_b_v) &&
                     (s_b_c == l_a_c) && (s_b_v == l_a_v);
        base_eq    = (s_b_c == l_b_c) && (s_b_v == l_b_v);
        both_const = s_a_c && l_a_c;

        s_off = signed'({s_a_v[OPND_W-1], s_a_v});
        l_off = signed'({l_a_v[OPND_W-1], l_a_v});
        s_end = s_off + signed'({{PAD_W{1'b0}}, s_bytes});
        l_end = l_off + signed'({{PAD_W{1'b0}}, l_bytes});

        if (s_off < l_off) ranges_meet = (s_end > l_off);
        else               ranges_meet = (l_end > s_off);

        hit = ent_vld && (same_order || swapped || (base_eq && both_const && ranges_meet));
    end
endmodule

// File: rtl/stld_table.sv
module stld_table
    import stld_pkg::*;
#(
    parameter int OPND_W = 12,
    parameter int DEPTH  = 5,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic                    wa_c,
    input  logic [OPND_W-1:0]       wa_v,
    input  logic                    wb_c,
    input  logic [OPND_W-1:0]       wb_v,
    input  logic [SZ_BYTES_W-1:0]   w_bytes,
    output logic                    ent_vld   [DEPTH],
    output logic                    ent_a_c   [DEPTH],
    output logic [OPND_W-1:0]       ent_a_v   [DEPTH],
    output logic                    ent_b_c   [DEPTH],
    output logic [OPND_W-1:0]       ent_b_v   [DEPTH],
    output logic [SZ_BYTES_W-1:0]   ent_bytes [DEPTH],
    output tbl_state_e              state,
    output logic [CNT_W-1:0]        count
);
    tbl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, base;
    logic             accept;

    // Next-state logic: the clear applies before a same-cycle store lands.
    always_comb begin
        base    = clr ? '0 : cnt_q;
        accept  = wr && (base < CNT_W'(DEPTH));
        cnt_d   = accept ? base + CNT_W'(1) : base;
        state_d = state_q;
        unique case (state_q)
            TBL_EMPTY: begin
                if (accept) state_d = (cnt_d == CNT_W'(DEPTH)) ? TBL_FULL : TBL_FILLING;
            end
            TBL_FILLING: begin
                if (clr && !accept) state_d = TBL_EMPTY;
                else if (accept)    state_d = (cnt_d == CNT_W'(DEPTH)) ? TBL_FULL : TBL_FILLING;
            end
            TBL_FULL: begin
                if (clr) state_d = accept ? TBL_FILLING : TBL_EMPTY;
            end
            default: state_d = TBL_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TBL_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic take;
        assign take = accept && (base == CNT_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n)    ent_vld[i] <= 1'b0;
            else if (take) ent_vld[i] <= 1'b1;
            else if (clr)  ent_vld[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (take) begin
                ent_a_c[i]   <= wa_c;
                ent_a_v[i]   <= wa_v;
                ent_b_c[i]   <= wb_c;
                ent_b_v[i]   <= wb_v;
                ent_bytes[i] <= w_bytes;
            end
        end
    end

    // Output process
    always_comb begin
        state = state_q;
        count = cnt_q;
    end
endmodule

// File: rtl/stld_overlap_det.sv
module stld_overlap_det
    import stld_pkg::*;
#(
    parameter int OPND_W = 12,
    parameter int DEPTH  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_end,
    input  logic              op_valid,
    input  logic              op_load,
    input  logic              op_store,
    input  logic              opa_const,
    input  logic [OPND_W-1:0] opa_val,
    input  logic              opb_const,
    input  logic [OPND_W-1:0] opb_val,
    input  logic [2:0]        op_size,
    output logic              hazard
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                  ent_vld   [DEPTH];
    logic                  ent_a_c   [DEPTH];
    logic [OPND_W-1:0]     ent_a_v   [DEPTH];
    logic                  ent_b_c   [DEPTH];
    logic [OPND_W-1:0]     ent_b_v   [DEPTH];
    logic [SZ_BYTES_W-1:0] ent_bytes [DEPTH];
    logic [DEPTH-1:0]      hits;
    logic [SZ_BYTES_W-1:0] op_bytes;
    tbl_state_e            tbl_state;
    logic [CNT_W-1:0]      tbl_count;

    assign op_bytes = size_to_bytes(op_size);

    stld_table #(.OPND_W(OPND_W), .DEPTH(DEPTH)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (grp_end),
        .wr        (op_valid && op_store),
        .wa_c      (opa_const),
        .wa_v      (opa_val),
        .wb_c      (opb_const),
        .wb_v      (opb_val),
        .w_bytes   (op_bytes),
        .ent_vld   (ent_vld),
        .ent_a_c   (ent_a_c),
        .ent_a_v   (ent_a_v),
        .ent_b_c   (ent_b_c),
        .ent_b_v   (ent_b_v),
        .ent_bytes (ent_bytes),
        .state     (tbl_state),
        .count     (tbl_count)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        stld_entry_cmp #(.OPND_W(OPND_W)) u_cmp (
            .ent_vld (ent_vld[i]),
            .s_a_c   (ent_a_c[i]),
            .s_a_v   (ent_a_v[i]),
            .s_b_c   (ent_b_c[i]),
            .s_b_v   (ent_b_v[i]),
            .s_bytes (ent_bytes[i]),
            .l_a_c   (opa_const),
            .l_a_v   (opa_val),
            .l_b_c   (opb_const),
            .l_b_v   (opb_val),
            .l_bytes (op_bytes),
            .hit     (hits[i])
        );
    end

    assign hazard = op_valid && op_load && (tbl_state != TBL_EMPTY) && (|hits);
endmodule

// File: rtl/stld_overlap_chk.sv
module stld_overlap_chk
    import stld_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grp_end,
    input logic             op_valid,
    input logic             op_store,
    input logic             hazard,
    input tbl_state_e       state,
    input logic [CNT_W-1:0] count
);
    logic st_now;
    assign st_now = op_valid && op_store;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_end && !st_now) |=> (count == '0 && state == TBL_EMPTY)); // R6

    AST_NO_HAZARD_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_end && !st_now) |=> !hazard); // R6

    AST_STORE_APPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_now && !grp_end && count < CNT_W'(DEPTH)) |=> count == $past(count) + CNT_W'(1)); // R1

    AST_FRESH_GROUP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_end && st_now) |=> count == CNT_W'(1)); // R7

    AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R8

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TBL_FULL && !grp_end) |=> (state == TBL_FULL && $stable(count))); // R8
endmodule

bind stld_overlap_det stld_overlap_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_end  (grp_end),
    .op_valid (op_valid),
    .op_store (op_store),
    .hazard   (hazard),
    .state    (tbl_state),
    .count    (tbl_count)
);

// File: tb/sim_stld_overlap_det.sv
module sim_stld_overlap_det;
    localparam int W = 12;
    localparam int NV = 31;

    typedef struct packed {
        logic         ge;
        logic         v;
        logic         ld;
        logic         st;
        logic         ac;
        logic [W-1:0] av;
        logic         bc;
        logic [W-1:0] bv;
        logic [2:0]   sz;
        logic         exp;
        logic [3:0]   req;
    } vec_t;

    // ge v ld st ac av bc bv sz exp req
    localparam vec_t VEC [NV] = '{
        '{1,0,0,0,0,12'd0,  0,12'd0, 3'd0,0,4'd6},  // R6 clear
        '{0,1,1,0,1,12'd8,  0,12'd5, 3'd2,0,4'd5},  // R5 load, empty table
        '{0,1,0,1,1,12'd8,  0,12'd5, 3'd3,0,4'd1},  // R1 store [8,16) base r5
        '{0,1,1,0,1,12'd8,  0,12'd5, 3'd2,1,4'd3},  // R3 same order
        '{0,1,1,0,0,12'd5,  1,12'd8, 3'd2,1,4'd3},  // R3 swapped
        '{0,1,1,0,1,12'd16, 0,12'd5, 3'd2,0,4'd4},  // R4 touches end, no overlap
        '{0,1,1,0,1,12'd15, 0,12'd5, 3'd0,1,4'd4},  // R4 last byte
        '{0,1,1,0,1,12'd4,  0,12'd5, 3'd2,0,4'd4},  // R4 below, touching
        '{0,1,1,0,1,12'd5,  0,12'd5, 3'd2,1,4'd4},  // R4 below, overlapping
        '{0,1,1,0,1,12'd8,  0,12'd6, 3'd2,0,4'd3},  // R3 other base
        '{0,1,1,0,0,12'd7,  0,12'd5, 3'd2,0,4'd4},  // R4 first operand not const
        '{0,1,0,1,1,12'hFF0,0,12'd9, 3'd4,0,4'd2},  // R2 store -16, 16 bytes
        '{0,1,1,0,1,12'hFFC,0,12'd9, 3'd0,1,4'd10}, // R10 older entry not hit, newer hit
        '{0,1,1,0,1,12'd0,  0,12'd9, 3'd1,0,4'd2},  // R2 -16+16 == 0, no overlap
        '{0,0,1,0,1,12'd8,  0,12'd5, 3'd2,0,4'd5},  // R5 not valid
        '{1,1,1,0,1,12'd8,  0,12'd5, 3'd2,1,4'd6},  // R6 old contents during clear
        '{0,1,1,0,1,12'd8,  0,12'd5, 3'd2,0,4'd6},  // R6 cleared
        '{1,1,0,1,1,12'd20, 0,12'd3, 3'd1,0,4'd7},  // R7 store with clear
        '{0,1,1,0,1,12'd21, 0,12'd3, 3'd0,1,4'd7},  // R7 fresh entry seen
        '{1,0,0,0,0,12'd0,  0,12'd0, 3'd0,0,4'd6},  // R6 clear
        '{0,1,0,1,1,12'd0,  0,12'd10,3'd0,0,4'd1},  // R1
        '{0,1,0,1,1,12'd0,  0,12'd11,3'd0,0,4'd1},  // R1
        '{0,1,0,1,1,12'd0,  0,12'd12,3'd0,0,4'd1},  // R1
        '{0,1,0,1,1,12'd0,  0,12'd13,3'd0,0,4'd1},  // R1
        '{0,1,0,1,1,12'd0,  0,12'd14,3'd0,0,4'd1},  // R1 fifth, table full
        '{0,1,0,1,1,12'd0,  0,12'd15,3'd0,0,4'd8},  // R8 sixth store dropped
        '{0,1,1,0,1,12'd0,  0,12'd15,3'd0,0,4'd8},  // R8 dropped store not seen
        '{0,1,1,0,1,12'd0,  0,12'd14,3'd0,1,4'd8},  // R8 fifth entry kept
        '{1,1,0,1,1,12'd0,  0,12'd20,3'd7,0,4'd2},  // R2 reserved code
        '{0,1,1,0,1,12'd15, 0,12'd20,3'd0,1,4'd2},  // R2 reserved acts as 16
        '{0,1,1,0,1,12'd16, 0,12'd20,3'd0,0,4'd2}   // R2 end of 16-byte range
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_end = 1'b0, op_valid = 1'b0, op_load = 1'b0, op_store = 1'b0;
    logic opa_const = 1'b0, opb_const = 1'b0;
    logic [W-1:0] opa_val = '0, opb_val = '0;
    logic [2:0] op_size = '0;
    logic hazard;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    stld_overlap_det #(.OPND_W(W), .DEPTH(5)) u0 (
        .clk(clk), .rst_n(rst_n), .grp_end(grp_end), .op_valid(op_valid),
        .op_load(op_load), .op_store(op_store), .opa_const(opa_const),
        .opa_val(opa_val), .opb_const(opb_const), .opb_val(opb_val),
        .op_size(op_size), .hazard(hazard)
    );

    task automatic check(input logic got, input logic exp, input int req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: hazard=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive(input vec_t t);
        grp_end = t.ge; op_valid = t.v; op_load = t.ld; op_store = t.st;
        opa_const = t.ac; opa_val = t.av; opb_const = t.bc; opb_val = t.bv;
        op_size = t.sz;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state: a load right after reset sees nothing
        @(negedge clk);
        drive('{0,1,1,0,1,12'd8,0,12'd5,3'd2,0,4'd9});
        #5 check(hazard, 1'b0, 9);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #5 check(hazard, VEC[i].exp, int'(VEC[i].req));
        end

        // R9: store, then reset, then the matching load must be clean
        @(negedge clk);
        drive('{1,1,0,1,1,12'd0,0,12'd30,3'd2,0,4'd9});
        @(negedge clk);
        drive('{0,1,1,0,1,12'd0,0,12'd30,3'd2,0,4'd9});
        #5 check(hazard, 1'b1, 9);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive('{0,1,1,0,1,12'd0,0,12'd30,3'd2,0,4'd9});
        #5 check(hazard, 1'b0, 9);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule